// File: doc/BRIEF.md
# Switching Connection Memory

This block holds one control word per channel of a time-division switch, 2048 words of 16 bits by default. A processor reaches any word through an asynchronous port of chip select, data strobe and a read/write select. The block answers with an active-low acknowledge once the access is done. While the processor works, the block also reads its own contents out in channel order, one word per channel slot, onto a parallel output bus.

A channel slot lasts two clocks. An internal channel counter advances once per slot. A frame pulse sampled on a clock edge restarts the counter at channel 0. The low 11 bits of each word read out serve as the read address of a separate data memory. The top 5 bits act as per-channel flags, for example an output enable or a message select.

There is a single storage array. The first clock of every slot belongs to the sequential readout. A processor access that falls on that clock waits one clock and runs on the second clock of the slot. Its acknowledge comes one clock later to match.

Top module: `conn_mem`

## Requirements
- R1: While reset is held and right after it, `dta_n` is 1, `chg` is 0, `seq_out` is 0 and `rdata` is 0.
- R2: A processor write (`rw`=0) stores `wdata` at `addr`. A later processor read (`rw`=1) of that address returns the word on `rdata`, valid while `dta_n` is low.
- R3: An access is requested by `cs_n` and `ds_n` both low. `dta_n` goes low on the edge that performs the access and stays low while the strobe is held. It returns to 1 on the third rising edge after the strobe is released.
- R4: The slot phase toggles on every clock. On each edge with phase 0, `seq_out` loads the word at the channel counter. The counter advances on each edge with phase 1 and wraps from 2047 to 0. All 16 bits are passed through.
- R5: When `frame_p` is 1 at an edge, the counter and phase are 0 afterwards. The next edge therefore loads word 0 onto `seq_out`.
- R6: Processor accesses run only on phase-1 edges. With the strobe asserted just before an edge of phase p, `dta_n` is observed low after 4 edges when p is 0 and after 5 edges when p is 1. The sequential readout is never disturbed by a processor access.
- R7: `chg` pulses high for exactly one clock after each processor write, while `dta_n` is low. A read produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge active |
| rst_n | input | 1 | asynchronous active-low reset |
| frame_p | input | 1 | frame pulse, restarts the channel counter |
| cs_n | input | 1 | processor chip select, active low |
| ds_n | input | 1 | processor data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 11 | processor word address |
| wdata | input | 16 | processor write data |
| rdata | output | 16 | processor read data |
| dta_n | output | 1 | access acknowledge, active low |
| seq_out | output | 16 | sequential readout word |
| chg | output | 1 | one-clock pulse after a processor write |

## Verification
Writes to every location fill the array first. After that, the readout stream is compared on every clock against a bench model of the counter and memory. Random reads and writes target addresses far from the running counter, so any corruption of the stream by processor traffic shows up as a mismatch, kept apart from ordinary data errors. The bench starts accesses in both slot phases and predicts the exact acknowledge latency, which separates correct deferral from accesses that run in the readout clock or wait too long. Frame pulses at random points, plus long runs across the counter wrap, test restart and wraparound. Pulse counts on `chg` separate writes from reads.

// File: rtl/conn_mem.sv
module conn_mem #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_p,
  input  logic          cs_n,
  input  logic          ds_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          dta_n,
  output logic [DW-1:0] seq_out,
  output logic          chg
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {IDLE, PEND, ACK} st_t;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] cnt;
  logic          phase;
  logic          s1, s2;
  st_t           state;

  wire strobe = ~cs_n & ~ds_n;
  wire go     = (state == PEND) & phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= strobe;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (frame_p) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk)
    if (go && !rw) mem[addr] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seq_out <= '0;
    else if (!phase) seq_out <= mem[cnt];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else if (go && rw) rdata <= mem[addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE;
      chg   <= 1'b0;
    end else begin
      chg <= go & ~rw;
      case (state)
        IDLE:    if (s2) state <= PEND;
        PEND:    if (phase) state <= ACK;
        ACK:     if (!s2) state <= IDLE;
        default: state <= IDLE;
      endcase
    end

  assign dta_n = (state != ACK);

  // R5
  frame_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_p |=> (cnt == '0 && !phase));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_p && phase) |=> cnt == AW'($past(cnt) + 1'b1));

  // R6
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PEND && !phase) |=> (state == PEND));

  // R7
  chg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !chg);

  // R7
  chg_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> !dta_n);

  // R3
  dta_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dta_n && !s2) |=> dta_n);
endmodule

// File: tb/tb_conn_mem.sv
module tb_conn_mem;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, frame_p = 0, cs_n = 1, ds_n = 1, rw = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, seq_out;
  logic dta_n, chg;

  conn_mem #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .frame_p(frame_p), .cs_n(cs_n), .ds_n(ds_n),
    .rw(rw), .addr(addr), .wdata(wdata), .rdata(rdata), .dta_n(dta_n),
    .seq_out(seq_out), .chg(chg));

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0, chg_cnt = 0;
  bit seq_chk = 0;
  logic [DW-1:0] mm [DEPTH];
  logic [AW-1:0] mc = '0;
  logic mp = 0;
  logic [DW-1:0] exp_seq = '0;

  function automatic int lat_exp(logic p);
    return p ? 5 : 4;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = '0; mp = 0; exp_seq = '0;
    end else begin
      if (!mp) exp_seq = mm[mc];
      if (frame_p) begin mc = '0; mp = 0; end
      else begin
        if (mp) mc = mc + 1'b1;
        mp = ~mp;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (chg === 1'b1) chg_cnt++;
    if (seq_chk) chk("R4 seq_out", seq_out, exp_seq);
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic access(input logic r, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input int hold);
    int n, m;
    logic p;
    @(negedge clk);
    p = mp;
    rw = r; addr = a; wdata = d; cs_n = 0; ds_n = 0; chg_cnt = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (dta_n !== 1'b0 && n < 40);
    chk("R6 latency", n, lat_exp(p));
    if (r) chk("R2 readback", rdata, mm[a]);
    else mm[a] = d;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R3 dta held", dta_n, 1'b0);
    end
    cs_n = 1; ds_n = 1;
    m = 0;
    do begin @(negedge clk); m++; end while (dta_n !== 1'b1 && m < 40);
    chk("R3 release", m, 3);
    @(negedge clk);
    chk("R7 chg pulses", chg_cnt, r ? 0 : 1);
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_p = 1;
    @(negedge clk); frame_p = 0;
    @(negedge clk);
    chk("R5 word0 after frame", seq_out, mm[0]);
  endtask

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 dta_n", dta_n, 1); chk("R1 chg", chg, 0);
    chk("R1 seq_out", seq_out, 0); chk("R1 rdata", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 dta_n after", dta_n, 1);
    for (int i = 0; i < DEPTH; i++) access(0, AW'(i), DW'($urandom), 0);
    @(negedge clk); seq_chk = 1;
    access(1, mc + 11'd600, 0, 0);
    for (int i = 0; i < 300; i++) begin
      a = mc + 11'd512 + AW'($urandom_range(0, 1023));
      access(1'($urandom), a, DW'($urandom), $urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) pulse_frame();
    end
    // R6 both phases directed
    while (mp !== 1'b0) @(negedge clk);
    access(1, mc + 11'd900, 0, 1);
    @(negedge clk);
    while (mp !== 1'b1) @(negedge clk);
    access(0, mc + 11'd900, 16'hF7FF, 1);
    pulse_frame();
    // R4 wrap: full frame and more without frame pulse
    repeat (DEPTH * 2 + 100) @(negedge clk);
    pulse_frame();
    seq_chk = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule